// File: doc/BRIEF.md
# Frame-Synchronized Serial Word Receiver

This block turns one serial data line into 32-bit parallel words. A one-cycle bit strobe marks each bit period, and the data and frame-sync lines are sampled only on strobe cycles. A frame sync starts a frame. After a programmable delay of zero, one or two bit periods, the receiver collects words until the frame is complete. A frame has one phase, or two phases when dual-phase framing is on. Each phase sets its own word length and word count. A finished word is placed in the 32-bit output in one of three justification formats. When 32-bit words arrive least significant bit first, their bit order can be reversed.

Finished words leave through a valid/ready stream. A word stays on `word_data` with `word_valid` high until a cycle in which `word_ready` is also high, and that cycle is the transfer. The receiver cannot stall the serial line. So when a word completes while an earlier word has not been taken, the earlier word stays in place, the new word is lost, and a sticky overrun flag is set. If a frame sync arrives while a frame is in progress, a sticky sync-error flag is set. Depending on a policy input, that sync either restarts the frame or is ignored. Driving `rx_en` low holds the receiver in reset and clears the output and both flags. One interrupt line reports a selected event.

Top module: `rxw_serial_rx`

## Requirements
- R1: Word length code per phase: 0=8, 1=12, 2=16, 3=20, 4=24 bits, and 5, 6 or 7=32 bits. Bits arrive most significant first. `word_valid` rises in the clock cycle after the strobe that carries a word's last bit.
- R2: The word count field holds the count minus one in 7 bits, so a phase has 1 to 128 words. After the last word of a frame, strobes without a frame sync produce no words.
- R3: When `dual_phase` is 1, phase one's words (`len1`/`cnt1`) are followed by phase two's words (`len2`/`cnt2`) in the same frame.
- R4: `delay_sel` 0 makes the sync strobe carry the first data bit. Value 1 puts the first data bit one strobe later, and 2 puts it two strobes later. Value 3 acts as 2.
- R5: `just_mode` 0 right-justifies with zero fill. 1 right-justifies and copies the word's top bit into all upper bits. 2 places the word at bit 31 downward with zero fill below. 3 acts as 0.
- R6: With `lsb_first`=1 and a 32-bit word, the word arrives least significant bit first and is output in normal order. With shorter words, `lsb_first` has no effect.
- R7: A sync strobe during a frame sets the sticky `sync_err`. With `ignore_fsync`=0 the frame restarts at that sync. With `ignore_fsync`=1 reception continues unchanged.
- R8: While `rx_en`=0 the receiver ignores all serial input. `word_valid`, `sync_err` and `overrun` are 0 one cycle after `rx_en` falls.
- R9: While `word_valid`=1 and `word_ready`=0, `word_valid` and `word_data` hold. A cycle with both high transfers the word.
- R10: If a word completes while a held word is untaken, the held word is kept and the sticky `overrun` flag sets.
- R11: `irq_sel` 0 (or 3) drives `rx_irq` from `word_valid`. 1 gives a one-cycle pulse per frame start. 2 drives `rx_irq` from `sync_err`.
- R12: After `rst_n` is released, `word_valid`, `sync_err`, `overrun` and `rx_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rx_en | input | 1 | Receiver enable; low holds the receiver in reset |
| bit_stb | input | 1 | One-cycle strobe per bit period |
| fsync | input | 1 | Frame sync, sampled on strobe cycles |
| sdata | input | 1 | Serial data, sampled on strobe cycles |
| dual_phase | input | 1 | Enables the second phase |
| len1 | input | 3 | Phase-one word length code |
| len2 | input | 3 | Phase-two word length code |
| cnt1 | input | 7 | Phase-one word count minus one |
| cnt2 | input | 7 | Phase-two word count minus one |
| delay_sel | input | 2 | Data delay after sync, in bits |
| just_mode | input | 2 | Justification format |
| lsb_first | input | 1 | Reverse order for 32-bit words |
| ignore_fsync | input | 1 | Ignore syncs that arrive during a frame |
| irq_sel | input | 2 | Interrupt source select |
| word_data | output | 32 | Received word |
| word_valid | output | 1 | Word available |
| word_ready | input | 1 | Consumer accepts the word |
| sync_err | output | 1 | Sticky sync-error flag |
| overrun | output | 1 | Sticky overrun flag |
| rx_irq | output | 1 | Selected interrupt |

## Verification
The bound checker checks the stream and flag rules on every cycle. A word held under back-pressure must stay fixed. Dropping the enable must clear the output and the flags. Both flags must stay set once raised. Overrun may only rise while a word is being held. The bench scenarios are the only place where the serial decoding is shown correct. These cover each word length and justification format, the data delays, two-phase frames, a 128-word phase, bit reversal, and the restart-versus-ignore handling of early syncs, all checked against words the bench computes itself.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
  localparam int WORD_W = 32;
  localparam int LEN_W  = 6;

  typedef enum logic [1:0] {ST_IDLE, ST_DLY, ST_SHIFT} rx_state_e;
  typedef enum logic [1:0] {JM_RZERO = 2'd0, JM_RSIGN = 2'd1, JM_LZERO = 2'd2, JM_SPARE = 2'd3} just_e;

  // Map a word length code to the number of bits in the word.
  function automatic logic [LEN_W-1:0] len_of(input logic [2:0] code);
    case (code)
      3'd0:    len_of = 6'd8;
      3'd1:    len_of = 6'd12;
      3'd2:    len_of = 6'd16;
      3'd3:    len_of = 6'd20;
      3'd4:    len_of = 6'd24;
      default: len_of = 6'd32;
    endcase
  endfunction
endpackage

// File: rtl/rxw_frame_ctl.sv
module rxw_frame_ctl
  import rxw_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              bit_stb,
  input  logic              fsync,
  input  logic              sdata,
  input  logic              dual_phase,
  input  logic [2:0]        len1,
  input  logic [2:0]        len2,
  input  logic [CNT_W-1:0]  cnt1,
  input  logic [CNT_W-1:0]  cnt2,
  input  logic [1:0]        delay_sel,
  input  logic              ignore_fsync,
  output logic              word_done,
  output logic [WORD_W-1:0] raw_word,
  output logic [2:0]        word_code,
  output logic              frame_start,
  output logic              sync_hit
);
  rx_state_e         state;
  logic [1:0]        dly_cnt;
  logic [LEN_W-1:0]  bit_cnt;
  logic [CNT_W-1:0]  word_cnt;
  logic              phase;
  logic [WORD_W-1:0] shreg;

  logic              live, busy, take_bit;
  logic [1:0]        dly_eff;
  logic              cur_phase;
  logic [LEN_W-1:0]  cur_bit, cur_len;
  logic [CNT_W-1:0]  cur_word, cur_cnt;
  logic              last_bit, last_word, last_phase;

  assign live        = bit_stb && rx_en;
  assign busy        = (state != ST_IDLE);
  assign sync_hit    = live && fsync && busy;
  assign frame_start = live && fsync && (!busy || !ignore_fsync);
  assign dly_eff     = (delay_sel == 2'd3) ? 2'd2 : delay_sel;

  // A restarting sync overrides the running position.
  assign cur_phase = frame_start ? 1'b0 : phase;
  assign cur_bit   = frame_start ? '0 : bit_cnt;
  assign cur_word  = frame_start ? '0 : word_cnt;
  assign word_code = cur_phase ? len2 : len1;
  assign cur_len   = len_of(word_code);
  assign cur_cnt   = cur_phase ? cnt2 : cnt1;

  assign take_bit = frame_start ? (dly_eff == 2'd0)
                  : (live && ((state == ST_SHIFT) || (state == ST_DLY && dly_cnt == 2'd0)));

  assign last_bit   = (cur_bit == cur_len - 6'd1);
  assign last_word  = (cur_word == cur_cnt);
  assign last_phase = cur_phase || !dual_phase;
  assign word_done  = take_bit && last_bit;
  assign raw_word   = {shreg[WORD_W-2:0], sdata};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      dly_cnt  <= '0;
      bit_cnt  <= '0;
      word_cnt <= '0;
      phase    <= 1'b0;
      shreg    <= '0;
    end else if (!rx_en) begin
      state    <= ST_IDLE;
      dly_cnt  <= '0;
      bit_cnt  <= '0;
      word_cnt <= '0;
      phase    <= 1'b0;
      shreg    <= '0;
    end else begin
      if (frame_start && dly_eff != 2'd0) begin
        state    <= ST_DLY;
        dly_cnt  <= dly_eff - 2'd1;
        phase    <= 1'b0;
        bit_cnt  <= '0;
        word_cnt <= '0;
      end else if (live && state == ST_DLY && dly_cnt != 2'd0) begin
        dly_cnt <= dly_cnt - 2'd1;
      end
      if (take_bit) begin
        shreg <= raw_word;
        state <= ST_SHIFT;
        phase <= cur_phase;
        if (last_bit) begin
          bit_cnt <= '0;
          if (last_word) begin
            word_cnt <= '0;
            if (last_phase) begin
              state <= ST_IDLE;
              phase <= 1'b0;
            end else begin
              phase <= 1'b1;
            end
          end else begin
            word_cnt <= cur_word + 1'b1;
          end
        end else begin
          bit_cnt  <= cur_bit + 6'd1;
          word_cnt <= cur_word;
        end
      end
    end
  end
endmodule

// File: rtl/rxw_justify.sv
module rxw_justify
  import rxw_pkg::*;
(
  input  logic [WORD_W-1:0] raw_word,
  input  logic [2:0]        word_code,
  input  logic [1:0]        just_mode,
  input  logic              lsb_first,
  output logic [WORD_W-1:0] out_word
);
  logic [WORD_W-1:0] reversed;
  logic [WORD_W-1:0] src, mask, base;
  logic [LEN_W-1:0]  len;
  logic              sign;

  for (genvar i = 0; i < WORD_W; i++) begin : g_rev
    assign reversed[i] = raw_word[WORD_W-1-i];
  end

  assign len  = len_of(word_code);
  assign mask = (len == 6'd32) ? '1 : ((32'd1 << len) - 32'd1);
  assign src  = (lsb_first && len == 6'd32) ? reversed : raw_word;
  assign base = src & mask;
  assign sign = src[len - 6'd1];

  always_comb begin
    case (just_e'(just_mode))
      JM_RSIGN: out_word = base | (sign ? ~mask : '0);
      JM_LZERO: out_word = base << (6'd32 - len);
      default:  out_word = base;
    endcase
  end
endmodule

// File: rtl/rxw_out_stage.sv
module rxw_out_stage
  import rxw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic              overrun
);
  logic accept_new;
  assign accept_new = in_valid && (!out_valid || out_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      overrun   <= 1'b0;
    end else if (!rx_en) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      overrun   <= 1'b0;
    end else begin
      if (accept_new) begin
        out_valid <= 1'b1;
        out_data  <= in_data;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
      if (in_valid && out_valid && !out_ready) overrun <= 1'b1;
    end
  end
endmodule

// File: rtl/rxw_serial_rx.sv
module rxw_serial_rx
  import rxw_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              bit_stb,
  input  logic              fsync,
  input  logic              sdata,
  input  logic              dual_phase,
  input  logic [2:0]        len1,
  input  logic [2:0]        len2,
  input  logic [CNT_W-1:0]  cnt1,
  input  logic [CNT_W-1:0]  cnt2,
  input  logic [1:0]        delay_sel,
  input  logic [1:0]        just_mode,
  input  logic              lsb_first,
  input  logic              ignore_fsync,
  input  logic [1:0]        irq_sel,
  output logic [WORD_W-1:0] word_data,
  output logic              word_valid,
  input  logic              word_ready,
  output logic              sync_err,
  output logic              overrun,
  output logic              rx_irq
);
  logic              word_done, frame_start, sync_hit;
  logic [WORD_W-1:0] raw_word, just_word;
  logic [2:0]        word_code;
  logic              start_pulse;

  rxw_frame_ctl #(.CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .bit_stb(bit_stb),
    .fsync(fsync), .sdata(sdata), .dual_phase(dual_phase),
    .len1(len1), .len2(len2), .cnt1(cnt1), .cnt2(cnt2),
    .delay_sel(delay_sel), .ignore_fsync(ignore_fsync),
    .word_done(word_done), .raw_word(raw_word), .word_code(word_code),
    .frame_start(frame_start), .sync_hit(sync_hit)
  );

  rxw_justify u_just (
    .raw_word(raw_word), .word_code(word_code), .just_mode(just_mode),
    .lsb_first(lsb_first), .out_word(just_word)
  );

  rxw_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .in_valid(word_done),
    .in_data(just_word), .out_ready(word_ready), .out_valid(word_valid),
    .out_data(word_data), .overrun(overrun)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_err    <= 1'b0;
      start_pulse <= 1'b0;
    end else if (!rx_en) begin
      sync_err    <= 1'b0;
      start_pulse <= 1'b0;
    end else begin
      if (sync_hit) sync_err <= 1'b1;
      start_pulse <= frame_start;
    end
  end

  always_comb begin
    case (irq_sel)
      2'd1:    rx_irq = start_pulse;
      2'd2:    rx_irq = sync_err;
      default: rx_irq = word_valid;
    endcase
  end
endmodule

// File: rtl/rxw_serial_rx_chk.sv
module rxw_serial_rx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_en,
  input logic [31:0] word_data,
  input logic        word_valid,
  input logic        word_ready,
  input logic        sync_err,
  input logic        overrun
);
  p_hold_under_backpressure_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !word_ready && rx_en) |=> (word_valid && $stable(word_data)));

  p_disable_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!word_valid && !sync_err && !overrun));

  p_overrun_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && rx_en) |=> overrun);

  p_overrun_needs_held_word_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(word_valid && !word_ready));

  p_sync_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_err && rx_en) |=> sync_err);
endmodule

bind rxw_serial_rx rxw_serial_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .word_data(word_data),
  .word_valid(word_valid), .word_ready(word_ready),
  .sync_err(sync_err), .overrun(overrun)
);

// File: tb/rxw_serial_rx_test.sv
`timescale 1ns/1ps
module rxw_serial_rx_test;
  logic clk = 1'b0, rst_n = 1'b0, rx_en = 1'b0, bit_stb = 1'b0, fsync = 1'b0, sdata = 1'b0;
  logic dual_phase = 1'b0, lsb_first = 1'b0, ignore_fsync = 1'b0, word_ready = 1'b1;
  logic [2:0] len1 = 3'd0, len2 = 3'd0;
  logic [6:0] cnt1 = 7'd0, cnt2 = 7'd0;
  logic [1:0] delay_sel = 2'd0, just_mode = 2'd0, irq_sel = 2'd0;
  logic [31:0] word_data;
  logic word_valid, sync_err, overrun, rx_irq;

  int n_chk = 0, n_err = 0, pulse_cnt = 0;
  bit q_bits[$];
  bit q_fs[$];
  bit pend_fs = 1'b0;
  logic [31:0] got[$];
  logic [31:0] expq[$];

  always #2.5 clk = ~clk;

  rxw_serial_rx uut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .bit_stb(bit_stb), .fsync(fsync),
    .sdata(sdata), .dual_phase(dual_phase), .len1(len1), .len2(len2),
    .cnt1(cnt1), .cnt2(cnt2), .delay_sel(delay_sel), .just_mode(just_mode),
    .lsb_first(lsb_first), .ignore_fsync(ignore_fsync), .irq_sel(irq_sel),
    .word_data(word_data), .word_valid(word_valid), .word_ready(word_ready),
    .sync_err(sync_err), .overrun(overrun), .rx_irq(rx_irq)
  );

  always @(negedge clk) begin
    if (word_valid && word_ready) got.push_back(word_data);
    if (rx_irq && irq_sel == 2'd1) pulse_cnt++;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int bits_of(input int code);
    int t[8] = '{8, 12, 16, 20, 24, 32, 32, 32};
    return t[code];
  endfunction

  function automatic logic [31:0] ref_word(input logic [31:0] v, input int len, input int mode);
    logic [31:0] r = '0;
    for (int i = 0; i < len; i++) begin
      if (mode == 2) r[32-len+i] = v[i];
      else r[i] = v[i];
    end
    if (mode == 1 && v[len-1]) for (int i = len; i < 32; i++) r[i] = 1'b1;
    return r;
  endfunction

  task automatic push_bit(input bit b);
    q_bits.push_back(b);
    q_fs.push_back(pend_fs);
    pend_fs = 1'b0;
  endtask

  task automatic push_word(input logic [31:0] v, input int len, input bit lsb);
    for (int i = 0; i < len; i++) push_bit(lsb ? v[i] : v[len-1-i]);
  endtask

  task automatic strobe(input bit fs, input bit d);
    @(negedge clk);
    fsync = fs; sdata = d; bit_stb = 1'b1;
    @(negedge clk);
    fsync = 1'b0; sdata = 1'b0; bit_stb = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic play();
    for (int i = 0; i < q_bits.size(); i++) strobe(q_fs[i], q_bits[i]);
    q_bits.delete();
    q_fs.delete();
    repeat (4) @(negedge clk);
  endtask

  task automatic expect_words(input string req);
    check(got.size() == expq.size(), {req, " word count"}, got.size(), expq.size());
    for (int i = 0; i < expq.size() && i < got.size(); i++)
      check(got[i] === expq[i], req, got[i], expq[i]);
    got.delete();
    expq.delete();
  endtask

  task automatic rx_cycle();
    @(negedge clk); rx_en = 1'b0;
    @(negedge clk); rx_en = 1'b1;
  endtask

  task automatic set_ready(input logic v);
    @(posedge clk); #1 word_ready = v;
  endtask

  task automatic t_reset();
    check(word_valid === 1'b0, "R12 valid", word_valid, 0);
    check(sync_err === 1'b0, "R12 sync_err", sync_err, 0);
    check(overrun === 1'b0, "R12 overrun", overrun, 0);
    check(rx_irq === 1'b0, "R12 irq", rx_irq, 0);
  endtask

  task automatic t_basic();
    len1 = 3'd0; cnt1 = 7'd1; delay_sel = 2'd0; just_mode = 2'd0;
    pend_fs = 1'b1; push_word(32'hA5, 8, 0); push_word(32'h3C, 8, 0);
    for (int i = 0; i < 8; i++) push_bit(1'b1);   // R2: no sync, must not yield a word
    expq.push_back(32'hA5); expq.push_back(32'h3C);
    play();
    expect_words("R2 two-word frame then idle");
    check(sync_err === 1'b0, "R7 no error on clean frame", sync_err, 0);
  endtask

  task automatic t_lengths();
    for (int c = 0; c < 8; c++) begin
      len1 = c[2:0]; cnt1 = 7'd0; just_mode = 2'd0;
      pend_fs = 1'b1; push_word(32'hC3A59E17, bits_of(c), 0);
      expq.push_back(ref_word(32'hC3A59E17, bits_of(c), 0));
      play();
      expect_words("R1 word length code");
    end
  endtask

  task automatic t_just();
    cnt1 = 7'd0;
    len1 = 3'd1; just_mode = 2'd1;
    pend_fs = 1'b1; push_word(32'h9F0, 12, 0); expq.push_back(32'hFFFFF9F0); play();
    pend_fs = 1'b1; push_word(32'h123, 12, 0); expq.push_back(32'h00000123); play();
    len1 = 3'd6;
    pend_fs = 1'b1; push_word(32'h80000001, 32, 0); expq.push_back(32'h80000001); play();
    expect_words("R5 sign extend");
    len1 = 3'd2; just_mode = 2'd2;
    pend_fs = 1'b1; push_word(32'hBEEF, 16, 0); expq.push_back(32'hBEEF0000); play();
    len1 = 3'd3; just_mode = 2'd3;
    pend_fs = 1'b1; push_word(32'hABCDE, 20, 0); expq.push_back(32'h000ABCDE); play();
    expect_words("R5 left and spare mode");
  endtask

  task automatic t_delay();
    len1 = 3'd0; cnt1 = 7'd0; just_mode = 2'd0;
    delay_sel = 2'd1;
    pend_fs = 1'b1; push_bit(1'b1); push_word(32'h5A, 8, 0); expq.push_back(32'h5A); play();
    delay_sel = 2'd2;
    pend_fs = 1'b1; push_bit(1'b1); push_bit(1'b1); push_word(32'h69, 8, 0); expq.push_back(32'h69); play();
    delay_sel = 2'd3;
    pend_fs = 1'b1; push_bit(1'b0); push_bit(1'b1); push_word(32'h2D, 8, 0); expq.push_back(32'h2D); play();
    expect_words("R4 data delay");
    delay_sel = 2'd0;
  endtask

  task automatic t_dual();
    dual_phase = 1'b1; len1 = 3'd0; cnt1 = 7'd0; len2 = 3'd3; cnt2 = 7'd1; just_mode = 2'd1;
    pend_fs = 1'b1;
    push_word(32'h81, 8, 0); push_word(32'hF00F1, 20, 0); push_word(32'h12345, 20, 0);
    for (int i = 0; i < 20; i++) push_bit(1'b0);
    expq.push_back(32'hFFFFFF81); expq.push_back(32'hFFFF00F1); expq.push_back(32'h00012345);
    play();
    expect_words("R3 dual phase frame");
    dual_phase = 1'b0; just_mode = 2'd0;
  endtask

  task automatic t_count();
    len1 = 3'd0; cnt1 = 7'd127;
    pend_fs = 1'b1;
    for (int i = 0; i < 128; i++) begin
      push_word(i * 7 + 3, 8, 0);
      expq.push_back((i * 7 + 3) & 32'hFF);
    end
    for (int i = 0; i < 8; i++) push_bit(1'b1);
    play();
    expect_words("R2 128-word phase");
    cnt1 = 7'd0;
  endtask

  task automatic t_reverse();
    cnt1 = 7'd0; lsb_first = 1'b1;
    len1 = 3'd5;
    pend_fs = 1'b1; push_word(32'h12345678, 32, 1); expq.push_back(32'h12345678); play();
    len1 = 3'd2;
    pend_fs = 1'b1; push_word(32'hBEEF, 16, 0); expq.push_back(32'h0000BEEF); play();
    expect_words("R6 bit reversal");
    lsb_first = 1'b0;
  endtask

  task automatic t_restart();
    len1 = 3'd0; cnt1 = 7'd0; ignore_fsync = 1'b0;
    pend_fs = 1'b1;
    for (int i = 0; i < 5; i++) push_bit(1'b1);
    pend_fs = 1'b1; push_word(32'h77, 8, 0);
    expq.push_back(32'h77);
    play();
    expect_words("R7 restart on early sync");
    check(sync_err === 1'b1, "R7 sync_err set", sync_err, 1);
    rx_cycle();
    @(negedge clk);
    check(sync_err === 1'b0, "R8 sync_err cleared by enable", sync_err, 0);
  endtask

  task automatic t_ignore();
    ignore_fsync = 1'b1; irq_sel = 2'd2;
    pend_fs = 1'b1; push_word(32'h96, 8, 0);
    q_fs[4] = 1'b1;
    expq.push_back(32'h96);
    play();
    expect_words("R7 ignored early sync");
    check(sync_err === 1'b1, "R7 sync_err set when ignored", sync_err, 1);
    check(rx_irq === 1'b1, "R11 irq from sync error", rx_irq, 1);
    rx_cycle();
    ignore_fsync = 1'b0; irq_sel = 2'd0;
  endtask

  task automatic t_overrun();
    len1 = 3'd0; cnt1 = 7'd1;
    set_ready(1'b0);
    pend_fs = 1'b1; push_word(32'h11, 8, 0); push_word(32'h22, 8, 0);
    play();
    check(word_valid === 1'b1, "R9 word held", word_valid, 1);
    check(word_data === 32'h11, "R10 older word kept", word_data, 32'h11);
    check(overrun === 1'b1, "R10 overrun set", overrun, 1);
    check(rx_irq === 1'b1, "R11 irq follows valid", rx_irq, 1);
    repeat (3) @(negedge clk);
    check(word_data === 32'h11, "R9 data stable", word_data, 32'h11);
    set_ready(1'b1);
    repeat (3) @(negedge clk);
    expq.push_back(32'h11);
    expect_words("R9 single transfer after ready");
    check(word_valid === 1'b0, "R9 valid drops after transfer", word_valid, 0);
    rx_cycle();
    @(negedge clk);
    check(overrun === 1'b0, "R8 overrun cleared", overrun, 0);
  endtask

  task automatic t_disabled();
    cnt1 = 7'd0; len1 = 3'd0;
    @(negedge clk); rx_en = 1'b0;
    pend_fs = 1'b1; push_word(32'hF0, 8, 0);
    play();
    check(word_valid === 1'b0, "R8 no word while disabled", word_valid, 0);
    expect_words("R8 disabled input ignored");
    @(negedge clk); rx_en = 1'b1;
  endtask

  task automatic t_irq_pulse();
    irq_sel = 2'd1; pulse_cnt = 0;
    pend_fs = 1'b1; push_word(32'h3E, 8, 0);
    expq.push_back(32'h3E);
    play();
    check(pulse_cnt == 1, "R11 one pulse per frame start", pulse_cnt, 1);
    expect_words("R11 frame under pulse mode");
    irq_sel = 2'd0;
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog R12 actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    rx_en = 1'b1;
    t_basic();
    t_lengths();
    t_just();
    t_delay();
    t_dual();
    t_count();
    t_reverse();
    t_restart();
    t_ignore();
    t_overrun();
    t_disabled();
    t_irq_pulse();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule